// File: doc/BRIEF.md
# Exception Entry State Controller

This block works out the architectural state that a processor core moves to when it takes an exception or is reset. The core pulses a request for one cycle and gives a 3-bit exception code, its current status word and its current program counter. One cycle later the block presents a complete set of updates:

- the new status word, with the mode field replaced and the interrupt masks set;
- a write of the old status word into one of the saved-status banks;
- a write of the link register for the bank that is entered;
- the new program counter.

A static configuration input selects between full 32-bit program addressing and a legacy 26-bit addressing scheme. In the legacy scheme the flags, the interrupt masks and a 2-bit mode are packed into the program counter word.

The same path handles synchronous reset. While reset is held, the block drives the reset-entry status and program counter for the selected configuration. The register file, instruction decode and pipeline control are separate blocks that consume these outputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `rst` is sampled high, the next cycle shows `upd_o`=1 with `save_we_o`=0 and `link_we_o`=0. `status_o` is 0x000000D3 when `cfg_addr32`=1 and 0x000000C3 otherwise. `pc_o` is 0x00000000 when `cfg_addr32`=1 and 0x0C000003 otherwise. Reset takes priority over a request sampled in the same cycle.
- R2: A request sampled with `req_valid`=1 drives `upd_o`, `save_we_o` and `link_we_o` high in the next cycle. A cycle with neither reset nor request is followed by all four strobes low, including `abt_idle_o`.
- R3: Exception codes are: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 address exception, 6 IRQ, 7 FIQ. The vector of code n is n*4.
- R4: `save_data_o` equals the status word that was presented with the request. The bank codes are 0 supervisor, 1 abort, 2 undefined, 3 IRQ and 4 FIQ.
  - Codes 0, 2 and 5 use the supervisor bank.
  - Code 6 uses the IRQ bank and code 7 uses the FIQ bank.
  - Code 1 uses the undefined bank and codes 3 and 4 use the abort bank, but only when `cfg_addr32`=1. Otherwise these three use the supervisor bank.
- R5: The new status sets bit 7 (IRQ mask) for every code. It sets bit 6 (FIQ mask) for codes 0 and 7 and otherwise keeps the incoming bit 6. Bits 31:8 and bit 5 are copied unchanged.
- R6: With `cfg_addr32`=1, the new mode in bits 4:0 is as follows: codes 0 and 2 give 10011, code 1 gives 11011, codes 3 and 4 give 10111, code 6 gives 10010 and code 7 gives 10001.
- R7: With `cfg_addr32`=0, codes 0 to 4 give mode 00011, code 6 gives 00010 and code 7 gives 00001. Code 5 gives 00011 in both configurations.
- R8: The link value is the base return value minus 4 for every code except 0, which stores the base unchanged.
- R9: The base return value depends on the configuration and the current mode.
  - With `cfg_addr32`=1 and incoming status bit 4 set, it is `cur_pc`.
  - With `cfg_addr32`=1 and bit 4 clear, it is `cur_pc` bits 25:2 with every other bit zero.
  - With `cfg_addr32`=0, it packs the incoming status into the PC word: bits 31:28 take status 31:28, bit 27 takes status bit 7, bit 26 takes status bit 6, bits 25:2 take `cur_pc` 25:2, and bits 1:0 take status 1:0.
- R10: When the new mode has bit 4 set, `pc_o` is the vector. Otherwise `pc_o` is the vector ORed with a word packed from the new status, using the same bit positions as R9.
- R11: `abt_idle_o` pulses high for exactly the cycle after a prefetch abort request (code 3). It asks the abort-address marker to return to its idle value.
- R12: `link_bank_o` equals `save_bank_o` on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; applies reset entry |
| req_valid | input | 1 | One-cycle exception request strobe |
| req_code | input | 3 | Exception code |
| cfg_addr32 | input | 1 | 1 = 32-bit addressing, 0 = 26-bit addressing |
| cur_status | input | DATA_W | Current status word |
| cur_pc | input | DATA_W | Current program counter |
| upd_o | output | 1 | Status and program counter update strobe |
| status_o | output | DATA_W | New status word |
| pc_o | output | DATA_W | New program counter |
| save_we_o | output | 1 | Saved-status bank write enable |
| save_bank_o | output | 3 | Saved-status bank index |
| save_data_o | output | DATA_W | Status word to save |
| link_we_o | output | 1 | Link register write enable |
| link_bank_o | output | 3 | Bank of the link register written |
| link_o | output | DATA_W | Link value |
| abt_idle_o | output | 1 | Abort-address marker return-to-idle pulse |

## Verification
Hardware reset and an exception request can fall in the same cycle. The bench drives `rst` and `req_valid` together, with a nonzero code and a status word that has neither mask bit set. It then expects the reset-entry status and program counter with both save and link writes suppressed, in both configurations.

A second overlap occurs when a 26-bit packing rule meets a 32-bit path. Two cases provoke it:

- an address exception in the 32-bit configuration, where the vector must still be packed with the new status;
- a request made while the core runs a 26-bit mode in the 32-bit configuration, where the link value must keep only the PC field.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_ADDR  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_FIQ   = 3'd7
  } exc_code_e;

  typedef enum logic [2:0] {
    BANK_SVC = 3'd0,
    BANK_ABT = 3'd1,
    BANK_UND = 3'd2,
    BANK_IRQ = 3'd3,
    BANK_FIQ = 3'd4
  } bank_e;

  localparam logic [4:0] MODE32_FIQ = 5'b10001;
  localparam logic [4:0] MODE32_IRQ = 5'b10010;
  localparam logic [4:0] MODE32_SVC = 5'b10011;
  localparam logic [4:0] MODE32_ABT = 5'b10111;
  localparam logic [4:0] MODE32_UND = 5'b11011;
  localparam logic [4:0] MODE26_FIQ = 5'b00001;
  localparam logic [4:0] MODE26_IRQ = 5'b00010;
  localparam logic [4:0] MODE26_SVC = 5'b00011;

  localparam int ST_IMASK  = 7;
  localparam int ST_FMASK  = 6;
  localparam int ST_WIDE   = 4;
  localparam int PK_IMASK  = 27;
  localparam int PK_FMASK  = 26;
  localparam int PK_PC_HI  = 25;
  localparam int PK_PC_LO  = 2;

  typedef struct packed {
    logic [4:0] mode;
    logic       set_fmask;
    bank_e      bank;
  } target_t;

endpackage

// File: rtl/exc_target_sel.sv
module exc_target_sel
  import exc_entry_pkg::*;
(
  input  logic [2:0] code,
  input  logic       addr32,
  output target_t    tgt
);
  always_comb begin
    tgt.set_fmask = 1'b0;
    tgt.bank      = BANK_SVC;
    tgt.mode      = addr32 ? MODE32_SVC : MODE26_SVC;
    case (exc_code_e'(code))
      EXC_RESET: tgt.set_fmask = 1'b1;
      EXC_UNDEF: begin
        tgt.bank = addr32 ? BANK_UND : BANK_SVC;
        tgt.mode = addr32 ? MODE32_UND : MODE26_SVC;
      end
      EXC_SWI: ;
      EXC_PABT, EXC_DABT: begin
        tgt.bank = addr32 ? BANK_ABT : BANK_SVC;
        tgt.mode = addr32 ? MODE32_ABT : MODE26_SVC;
      end
      EXC_ADDR: tgt.mode = MODE26_SVC;
      EXC_IRQ: begin
        tgt.bank = BANK_IRQ;
        tgt.mode = addr32 ? MODE32_IRQ : MODE26_IRQ;
      end
      EXC_FIQ: begin
        tgt.bank      = BANK_FIQ;
        tgt.set_fmask = 1'b1;
        tgt.mode      = addr32 ? MODE32_FIQ : MODE26_FIQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
  import exc_entry_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_OFS = 4
) (
  input  logic [2:0]        code,
  input  logic              addr32,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] link
);
  logic [DATA_W-1:0] pc_field;
  logic [DATA_W-1:0] base;

  always_comb begin
    pc_field = '0;
    pc_field[PK_PC_HI:PK_PC_LO] = pc[PK_PC_HI:PK_PC_LO];
    if (addr32) begin
      base = status[ST_WIDE] ? pc : pc_field;
    end else begin
      base = pc_field;
      base[DATA_W-1:PK_IMASK+1] = status[DATA_W-1:PK_IMASK+1];
      base[PK_IMASK] = status[ST_IMASK];
      base[PK_FMASK] = status[ST_FMASK];
      base[1:0]      = status[1:0];
    end
    link = (exc_code_e'(code) == EXC_RESET) ? base : base - DATA_W'(LINK_OFS);
  end
endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc
  import exc_entry_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int VEC_STRIDE = 4
) (
  input  logic [2:0]        code,
  input  logic [DATA_W-1:0] new_status,
  output logic [DATA_W-1:0] pc
);
  logic [DATA_W-1:0] vec;
  logic [DATA_W-1:0] packed_st;

  always_comb begin
    vec = DATA_W'(code) * DATA_W'(VEC_STRIDE);
    packed_st = '0;
    packed_st[DATA_W-1:PK_IMASK+1] = new_status[DATA_W-1:PK_IMASK+1];
    packed_st[PK_IMASK] = new_status[ST_IMASK];
    packed_st[PK_FMASK] = new_status[ST_FMASK];
    packed_st[1:0]      = new_status[1:0];
    pc = new_status[ST_WIDE] ? vec : (vec | packed_st);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINK_OFS   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_code,
  input  logic              cfg_addr32,
  input  logic [DATA_W-1:0] cur_status,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              upd_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              save_we_o,
  output logic [2:0]        save_bank_o,
  output logic [DATA_W-1:0] save_data_o,
  output logic              link_we_o,
  output logic [2:0]        link_bank_o,
  output logic [DATA_W-1:0] link_o,
  output logic              abt_idle_o
);
  localparam logic [DATA_W-1:0] RST_ST32 =
    DATA_W'((1 << ST_IMASK) | (1 << ST_FMASK)) | DATA_W'(MODE32_SVC);
  localparam logic [DATA_W-1:0] RST_ST26 =
    DATA_W'((1 << ST_IMASK) | (1 << ST_FMASK)) | DATA_W'(MODE26_SVC);
  localparam logic [DATA_W-1:0] RST_PC26 =
    (DATA_W'(1) << PK_IMASK) | (DATA_W'(1) << PK_FMASK) | DATA_W'(MODE26_SVC[1:0]);

  target_t           tgt;
  logic [DATA_W-1:0] nxt_status;
  logic [DATA_W-1:0] nxt_link;
  logic [DATA_W-1:0] nxt_pc;

  exc_target_sel u_sel (
    .code   (req_code),
    .addr32 (cfg_addr32),
    .tgt    (tgt)
  );

  always_comb begin
    nxt_status = cur_status;
    nxt_status[4:0]      = tgt.mode;
    nxt_status[ST_IMASK] = 1'b1;
    nxt_status[ST_FMASK] = cur_status[ST_FMASK] | tgt.set_fmask;
  end

  exc_link_calc #(.DATA_W(DATA_W), .LINK_OFS(LINK_OFS)) u_link (
    .code   (req_code),
    .addr32 (cfg_addr32),
    .status (cur_status),
    .pc     (cur_pc),
    .link   (nxt_link)
  );

  exc_pc_calc #(.DATA_W(DATA_W), .VEC_STRIDE(VEC_STRIDE)) u_pc (
    .code       (req_code),
    .new_status (nxt_status),
    .pc         (nxt_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_o       <= 1'b1;
      save_we_o   <= 1'b0;
      link_we_o   <= 1'b0;
      abt_idle_o  <= 1'b0;
      status_o    <= cfg_addr32 ? RST_ST32 : RST_ST26;
      pc_o        <= cfg_addr32 ? '0 : RST_PC26;
      save_bank_o <= BANK_SVC;
      link_bank_o <= BANK_SVC;
      save_data_o <= '0;
      link_o      <= '0;
    end else begin
      upd_o      <= req_valid;
      save_we_o  <= req_valid;
      link_we_o  <= req_valid;
      abt_idle_o <= req_valid && (exc_code_e'(req_code) == EXC_PABT);
      if (req_valid) begin
        status_o    <= nxt_status;
        pc_o        <= nxt_pc;
        save_bank_o <= tgt.bank;
        link_bank_o <= tgt.bank;
        save_data_o <= cur_status;
        link_o      <= nxt_link;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_code,
  input logic [DATA_W-1:0] cur_status,
  input logic              upd_o,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              save_we_o,
  input logic [2:0]        save_bank_o,
  input logic [DATA_W-1:0] save_data_o,
  input logic              link_we_o,
  input logic              abt_idle_o
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_state_R1: assert (upd_o && !save_we_o && !link_we_o && status_o[7:6] == 2'b11)
        else $error("reset entry state wrong");
    end
  end

  assert_req_update_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (upd_o && save_we_o && link_we_o));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(upd_o || save_we_o || link_we_o || abt_idle_o));

  assert_status_copy_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (save_data_o == $past(cur_status)));

  assert_bank_range_R4: assert property (@(posedge clk) disable iff (rst)
    save_we_o |-> (save_bank_o <= 3'd4));

  assert_imask_set_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> status_o[7]);

  assert_fmask_set_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_code == 3'd7 || req_code == 3'd0)) |=> status_o[6]);

  assert_vector32_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_o && status_o[4]) |-> (pc_o[DATA_W-1:5] == '0 && pc_o[1:0] == 2'b00));

  assert_abt_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_code == 3'd3) |=> abt_idle_o);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_code    (req_code),
  .cur_status  (cur_status),
  .upd_o       (upd_o),
  .status_o    (status_o),
  .pc_o        (pc_o),
  .save_we_o   (save_we_o),
  .save_bank_o (save_bank_o),
  .save_data_o (save_data_o),
  .link_we_o   (link_we_o),
  .abt_idle_o  (abt_idle_o)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_code = 3'd0;
  logic        cfg_addr32 = 1'b1;
  logic [31:0] cur_status = 32'h0;
  logic [31:0] cur_pc = 32'h0;
  logic        upd_o, save_we_o, link_we_o, abt_idle_o;
  logic [31:0] status_o, pc_o, save_data_o, link_o;
  logic [2:0]  save_bank_o, link_bank_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .cfg_addr32(cfg_addr32), .cur_status(cur_status), .cur_pc(cur_pc),
    .upd_o(upd_o), .status_o(status_o), .pc_o(pc_o),
    .save_we_o(save_we_o), .save_bank_o(save_bank_o), .save_data_o(save_data_o),
    .link_we_o(link_we_o), .link_bank_o(link_bank_o), .link_o(link_o),
    .abt_idle_o(abt_idle_o)
  );

  typedef struct packed {
    logic [31:0] st;
    logic [31:0] pc;
    logic [2:0]  bank;
    logic [31:0] link;
  } exp_t;

  function automatic logic [31:0] pack26(input logic [31:0] s, input logic [23:0] pcf);
    return {s[31:28], s[7], s[6], pcf, s[1:0]};
  endfunction

  function automatic exp_t model(input logic [2:0] c, input logic a32,
                                 input logic [31:0] st, input logic [31:0] pc);
    exp_t e;
    logic [4:0] m;
    logic [2:0] b;
    logic       f;
    logic [31:0] base;
    f = (c == 3'd0) || (c == 3'd7);
    case (c)
      3'd1: begin m = a32 ? 5'b11011 : 5'b00011; b = a32 ? 3'd2 : 3'd0; end
      3'd3, 3'd4: begin m = a32 ? 5'b10111 : 5'b00011; b = a32 ? 3'd1 : 3'd0; end
      3'd5: begin m = 5'b00011; b = 3'd0; end
      3'd6: begin m = a32 ? 5'b10010 : 5'b00010; b = 3'd3; end
      3'd7: begin m = a32 ? 5'b10001 : 5'b00001; b = 3'd4; end
      default: begin m = a32 ? 5'b10011 : 5'b00011; b = 3'd0; end
    endcase
    e.st = st;
    e.st[4:0] = m;
    e.st[7] = 1'b1;
    if (f) e.st[6] = 1'b1;
    if (a32) base = st[4] ? pc : {6'b0, pc[25:2], 2'b00};
    else     base = pack26(st, pc[25:2]);
    e.link = (c == 3'd0) ? base : base - 32'd4;
    e.bank = b;
    e.pc = e.st[4] ? {27'b0, c, 2'b00}
                   : ({27'b0, c, 2'b00} | pack26(e.st, 24'h0));
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic a32,
                       input logic [31:0] st, input logic [31:0] pc);
    exp_t e;
    e = model(c, a32, st, pc);
    req_code = c; cfg_addr32 = a32; cur_status = st; cur_pc = pc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 strobes", {29'b0, upd_o, save_we_o, link_we_o}, 32'h7);
    chk("R5/R6/R7 status", status_o, e.st);
    chk("R3/R10 pc", pc_o, e.pc);
    chk("R4 save bank", {29'b0, save_bank_o}, {29'b0, e.bank});
    chk("R4 save data", save_data_o, st);
    chk("R8/R9 link", link_o, e.link);
    chk("R12 link bank", {29'b0, link_bank_o}, {29'b0, e.bank});
    chk("R11 abort pulse", {31'b0, abt_idle_o}, {31'b0, c == 3'd3});
  endtask

  task automatic check_reset(input logic a32);
    chk("R1 reset strobes", {29'b0, upd_o, save_we_o, link_we_o}, 32'h4);
    chk("R1 reset status", status_o, a32 ? 32'h000000D3 : 32'h000000C3);
    chk("R1 reset pc", pc_o, a32 ? 32'h0 : 32'h0C000003);
  endtask

  task automatic check_idle();
    @(negedge clk);
    chk("R2 idle", {28'b0, upd_o, save_we_o, link_we_o, abt_idle_o}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    // R1 reset in both configurations
    cfg_addr32 = 1'b1;
    @(negedge clk); @(negedge clk);
    check_reset(1'b1);
    cfg_addr32 = 1'b0;
    @(negedge clk);
    check_reset(1'b0);
    rst = 1'b0;
    check_idle();

    // R1 reset coincident with request, both configurations
    for (int k = 0; k < 2; k++) begin
      cfg_addr32 = k[0]; rst = 1'b1; req_valid = 1'b1; req_code = 3'd6;
      cur_status = 32'hF0000010; cur_pc = 32'h00001000;
      @(negedge clk);
      check_reset(k[0]);
      rst = 1'b0; req_valid = 1'b0;
      check_idle();
    end

    // Directed: every code, both configurations
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 8; c++) begin
        apply(c[2:0], a[0], 32'hA0000013, 32'h00400108);
        check_idle();
      end

    // R9: 32-bit config running a 26-bit mode; R7 address exception in 32-bit config
    apply(3'd2, 1'b1, 32'h50000082, 32'hFC00_1234);
    apply(3'd5, 1'b1, 32'h30000013, 32'h0000_2000);
    apply(3'd0, 1'b0, 32'hF00000C1, 32'hFFFF_FFFF);
    // R8: zero PC wraps on offset
    apply(3'd6, 1'b1, 32'h00000013, 32'h0);
    check_idle();

    // Random mix
    for (int i = 0; i < 400; i++) begin
      apply(3'($urandom), 1'($urandom), $urandom, $urandom);
      if ((i % 7) == 0) check_idle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule